// File: doc/BRIEF.md
# Virtualized Pipeline Stripe Sequencer

This block lets a pipeline with more virtual stages than physical stripes run on a fixed fabric. Every cycle it picks the next physical stripe in rotation and reads the configuration and the saved register state of the next virtual stage from two external memories. One cycle later it loads both into that stripe. All other stripes keep running during that cycle. If the stripe being replaced still holds a live stage, its register contents are written back to the state memory one cycle before the overwrite, at the index of the stage leaving the fabric. A later pass can then refill exactly what was evicted.

Software writes a stage count and pulses start. If the pipeline fits on the fabric, each stage is loaded once and the sequencer goes idle. If it does not fit, the virtual stages rotate through the stripes for as long as the block runs. The stripe datapath is reduced to one state register per stripe. A datapath write port and an observation port stand in for the execution logic.

Top module: `stripe_seq`

## Requirements
- R1: While reset is held and after it is released, with no start, all read, write, load and save strobes are low and every bit of `stripe_valid` is 0.
- R2: A start with a legal count N (1..MAX_VSTAGES) begins issuing in the next cycle. Issue cycle k (k = 0, 1, …) raises `cfg_ren` and `st_ren` with `cfg_raddr` = `st_raddr` = k mod N.
- R3: The stripe filled by issue cycle k is slot k mod NUM_SLOTS. In cycle k+1, `stage_load` is one-hot on that slot and `cfg_bus` carries the configuration word read in cycle k. No other slot is loaded in that cycle.
- R4: A slot that is loaded takes the state memory read data as its register contents. From the next cycle that value is visible on `obs_data`.
- R5: When N > NUM_SLOTS, every issue cycle from k = NUM_SLOTS onward sets bit k mod NUM_SLOTS of `reg_save` and writes the slot's current register through `st_we`. The write address `st_waddr` is (k − NUM_SLOTS) mod N, the stage being evicted. A value saved this way comes back when that stage is loaded again.
- R6: When N ≤ NUM_SLOTS, exactly N issue cycles occur. After them no read, write or load happens, and `stripe_valid` has its low N bits set.
- R7: A slot reads as not valid in `stripe_valid` during the cycle in which it is loaded.
- R8: A datapath write changes a slot only if that slot is valid and is not being saved in that cycle. Otherwise the slot register keeps its value.
- R9: A legal start while the sequencer is busy restarts from stage 0 in slot 0. It cancels a load in flight and clears all valid bits.
- R10: A start with a count of 0 or greater than MAX_VSTAGES is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new run with `vcount` stages |
| vcount | input | VC_W | Number of virtual stages |
| cfg_ren | output | 1 | Configuration memory read enable |
| cfg_raddr | output | VA_W | Configuration memory read address (virtual stage) |
| cfg_rdata | input | CFG_W | Configuration word, one cycle after the read |
| cfg_bus | output | CFG_W | Configuration word delivered to the stripe being loaded |
| stage_load | output | NUM_SLOTS | One-hot strobe: load configuration and restore state into that slot |
| st_ren | output | 1 | State memory read enable |
| st_raddr | output | VA_W | State memory read address |
| st_rdata | input | STATE_W | State memory read data, one cycle after the read |
| st_we | output | 1 | State memory write enable (spill) |
| st_waddr | output | VA_W | State memory write address (evicted stage) |
| st_wdata | output | STATE_W | Register contents being spilled |
| reg_save | output | NUM_SLOTS | One-hot strobe: slot whose register is being saved |
| stripe_valid | output | NUM_SLOTS | Slot holds a configured stage and is not being loaded |
| dp_we | input | 1 | Datapath register write enable |
| dp_slot | input | SL_W | Slot targeted by the datapath write |
| dp_wdata | input | STATE_W | Datapath write data |
| obs_slot | input | SL_W | Slot selected for observation |
| obs_data | output | STATE_W | Register contents of the observed slot |

## Verification
The assertions assume that both memories return data exactly one cycle after a read and that start is a pulse. They also assume the datapath does not target a slot index at or above NUM_SLOTS. The stimulus holds start for one cycle and drives inputs only on falling edges. It models the memories as registered arrays with one-cycle latency and keeps `dp_slot` and `obs_slot` inside the slot range. Reset is applied again before each scenario, so the state memory image starts from known contents every time.

// File: rtl/stripe_seq_pkg.sv
// Shared types for the stripe sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package stripe_seq_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/stripe_seq_ctrl.sv
// Issue controller: steps the virtual-stage and physical-slot pointers,
// drives the memory read and spill-write ports, and remembers which stage
// each slot holds so that an eviction writes back to the right index.
// Assumes memories with one-cycle read latency.
module stripe_seq_ctrl
    import stripe_seq_pkg::*;
#(
    parameter int NUM_SLOTS   = 28,
    parameter int MAX_VSTAGES = 256,
    parameter int VA_W        = 8,
    parameter int VC_W        = 9,
    parameter int SL_W        = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [VC_W-1:0]      vcount,
    output logic                 issue,
    output logic [VA_W-1:0]      issue_vstage,
    output logic [SL_W-1:0]      issue_slot,
    output logic                 spill,
    output logic [VA_W-1:0]      spill_vstage,
    output logic                 restart,
    output logic                 load_en,
    output logic [SL_W-1:0]      load_slot,
    output logic [NUM_SLOTS-1:0] save_oh,
    output logic [NUM_SLOTS-1:0] load_oh
);

    localparam logic [VC_W-1:0] ONE_C   = VC_W'(1);
    localparam logic [VC_W-1:0] SLOTS_C = VC_W'(NUM_SLOTS);
    localparam logic [VC_W-1:0] MAXV_C  = VC_W'(MAX_VSTAGES);
    localparam logic [SL_W-1:0] LAST_S  = SL_W'(NUM_SLOTS - 1);

    seq_state_e      state_q;
    logic [VC_W-1:0] nstg_q;
    logic [VA_W-1:0] vptr_q;
    logic [SL_W-1:0] sptr_q;
    logic            filled_q;
    logic            pend_q;
    logic [SL_W-1:0] pslot_q;
    logic [VA_W-1:0] tag_q [NUM_SLOTS];
    logic            last_v;
    logic            last_s;

    // accept a start only with a legal stage count
    assign restart      = start && (vcount != '0) && (vcount <= MAXV_C);
    assign issue        = (state_q == SEQ_RUN);
    assign issue_vstage = vptr_q;
    assign issue_slot   = sptr_q;
    assign spill        = issue && filled_q;
    assign spill_vstage = tag_q[sptr_q];
    assign load_en      = pend_q;
    assign load_slot    = pslot_q;
    assign last_v       = (VC_W'(vptr_q) == nstg_q - ONE_C);
    assign last_s       = (sptr_q == LAST_S);

    // one-hot decode of the save and load slots
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_dec
        assign save_oh[g] = spill && (sptr_q == SL_W'(g));
        assign load_oh[g] = pend_q && (pslot_q == SL_W'(g));
    end

    // pointer stepping, stage tags and pending-load tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            nstg_q   <= '0;
            vptr_q   <= '0;
            sptr_q   <= '0;
            filled_q <= 1'b0;
            pend_q   <= 1'b0;
            pslot_q  <= '0;
            for (int i = 0; i < NUM_SLOTS; i++) tag_q[i] <= '0;
        end else if (restart) begin
            state_q  <= SEQ_RUN;
            nstg_q   <= vcount;
            vptr_q   <= '0;
            sptr_q   <= '0;
            filled_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            pend_q  <= issue;
            pslot_q <= sptr_q;
            if (issue) begin
                tag_q[sptr_q] <= vptr_q;
                vptr_q <= last_v ? '0 : vptr_q + 1'b1;
                sptr_q <= last_s ? '0 : sptr_q + 1'b1;
                if (last_s) filled_q <= 1'b1;
                if (last_v && (nstg_q <= SLOTS_C)) state_q <= SEQ_IDLE;
            end
        end
    end

endmodule

// File: rtl/stripe_seq_regs.sv
// Per-slot stripe register storage: restore on load, datapath writes while
// the slot is live, read muxes for spill and observation.
// Assumes at most one load per cycle (guaranteed by the controller).
module stripe_seq_regs #(
    parameter int NUM_SLOTS = 28,
    parameter int STATE_W   = 128,
    parameter int SL_W      = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic [NUM_SLOTS-1:0] load_oh,
    input  logic [STATE_W-1:0]   load_data,
    input  logic [NUM_SLOTS-1:0] save_oh,
    input  logic                 wr_en,
    input  logic [SL_W-1:0]      wr_slot,
    input  logic [STATE_W-1:0]   wr_data,
    input  logic [SL_W-1:0]      spill_slot,
    output logic [STATE_W-1:0]   spill_data,
    input  logic [SL_W-1:0]      rd_slot,
    output logic [STATE_W-1:0]   rd_data,
    output logic [NUM_SLOTS-1:0] valid
);

    logic [STATE_W-1:0] regs_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] loaded_q;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic wr_hit;
        assign wr_hit   = wr_en && (wr_slot == SL_W'(g)) && valid[g] && !save_oh[g];
        assign valid[g] = loaded_q[g] && !load_oh[g];

        // configured flag: cleared on restart, set by a load
        always_ff @(posedge clk) begin
            if (!rst_n || restart) loaded_q[g] <= 1'b0;
            else if (load_oh[g])   loaded_q[g] <= 1'b1;
        end

        // register contents: restore wins over datapath writes
        always_ff @(posedge clk) begin
            if (!rst_n)          regs_q[g] <= '0;
            else if (load_oh[g]) regs_q[g] <= load_data;
            else if (wr_hit)     regs_q[g] <= wr_data;
        end
    end

    // read muxes, zero outside the slot range
    assign spill_data = (int'(spill_slot) < NUM_SLOTS) ? regs_q[spill_slot] : '0;
    assign rd_data    = (int'(rd_slot) < NUM_SLOTS) ? regs_q[rd_slot] : '0;

endmodule

// File: rtl/stripe_seq.sv
// Top: runs a virtual pipeline of up to MAX_VSTAGES stages on NUM_SLOTS
// physical stripes, reconfiguring one stripe per cycle in rotation and
// spilling/refilling stripe registers through an external state memory.
// Assumes both memories answer a read one cycle later.
module stripe_seq #(
    parameter int NUM_SLOTS   = 28,
    parameter int MAX_VSTAGES = 256,
    parameter int CFG_W       = 1024,
    parameter int PE_COUNT    = 32,
    parameter int PE_W        = 4,
    localparam int STATE_W    = PE_COUNT * PE_W,
    localparam int VA_W       = (MAX_VSTAGES > 1) ? $clog2(MAX_VSTAGES) : 1,
    localparam int VC_W       = $clog2(MAX_VSTAGES + 1),
    localparam int SL_W       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [VC_W-1:0]      vcount,
    output logic                 cfg_ren,
    output logic [VA_W-1:0]      cfg_raddr,
    input  logic [CFG_W-1:0]     cfg_rdata,
    output logic [CFG_W-1:0]     cfg_bus,
    output logic [NUM_SLOTS-1:0] stage_load,
    output logic                 st_ren,
    output logic [VA_W-1:0]      st_raddr,
    input  logic [STATE_W-1:0]   st_rdata,
    output logic                 st_we,
    output logic [VA_W-1:0]      st_waddr,
    output logic [STATE_W-1:0]   st_wdata,
    output logic [NUM_SLOTS-1:0] reg_save,
    output logic [NUM_SLOTS-1:0] stripe_valid,
    input  logic                 dp_we,
    input  logic [SL_W-1:0]      dp_slot,
    input  logic [STATE_W-1:0]   dp_wdata,
    input  logic [SL_W-1:0]      obs_slot,
    output logic [STATE_W-1:0]   obs_data
);

    logic            issue;
    logic [VA_W-1:0] issue_vstage;
    logic [SL_W-1:0] issue_slot;
    logic            spill;
    logic [VA_W-1:0] spill_vstage;
    logic            restart;
    logic            load_en;
    logic [SL_W-1:0] load_slot;
    logic [NUM_SLOTS-1:0] save_oh;
    logic [NUM_SLOTS-1:0] load_oh;

    stripe_seq_ctrl #(
        .NUM_SLOTS(NUM_SLOTS), .MAX_VSTAGES(MAX_VSTAGES),
        .VA_W(VA_W), .VC_W(VC_W), .SL_W(SL_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .vcount(vcount),
        .issue(issue), .issue_vstage(issue_vstage), .issue_slot(issue_slot),
        .spill(spill), .spill_vstage(spill_vstage), .restart(restart),
        .load_en(load_en), .load_slot(load_slot),
        .save_oh(save_oh), .load_oh(load_oh)
    );

    stripe_seq_regs #(
        .NUM_SLOTS(NUM_SLOTS), .STATE_W(STATE_W), .SL_W(SL_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .load_oh(load_oh), .load_data(st_rdata), .save_oh(save_oh),
        .wr_en(dp_we), .wr_slot(dp_slot), .wr_data(dp_wdata),
        .spill_slot(issue_slot), .spill_data(st_wdata),
        .rd_slot(obs_slot), .rd_data(obs_data), .valid(stripe_valid)
    );

    // memory ports and stripe strobes
    assign cfg_ren    = issue;
    assign cfg_raddr  = issue_vstage;
    assign st_ren     = issue;
    assign st_raddr   = issue_vstage;
    assign st_we      = spill;
    assign st_waddr   = spill_vstage;
    assign reg_save   = save_oh;
    assign stage_load = load_oh;
    assign cfg_bus    = cfg_rdata;

endmodule

// File: rtl/stripe_seq_chk.sv
// Protocol checker for stripe_seq, attached by bind.
// Assumes start is a pulse and memories have one-cycle read latency.
module stripe_seq_chk #(
    parameter int NUM_SLOTS = 28,
    parameter int VA_W      = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 cfg_ren,
    input logic                 st_ren,
    input logic                 st_we,
    input logic [VA_W-1:0]      st_raddr,
    input logic [VA_W-1:0]      st_waddr,
    input logic [NUM_SLOTS-1:0] stage_load,
    input logic [NUM_SLOTS-1:0] reg_save,
    input logic [NUM_SLOTS-1:0] stripe_valid
);

    a_r3_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stage_load));

    a_r3_load_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ren && !start) |=> $onehot(stage_load));

    a_r3_load_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_load != '0) |-> $past(cfg_ren));

    a_r7_loading_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ((stage_load & stripe_valid) == '0));

    a_r5_save_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_save));

    a_r5_spill_with_refill: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> (st_ren && (st_waddr != st_raddr)));

endmodule

bind stripe_seq stripe_seq_chk #(.NUM_SLOTS(NUM_SLOTS), .VA_W(VA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_ren(cfg_ren),
    .st_ren(st_ren), .st_we(st_we), .st_raddr(st_raddr), .st_waddr(st_waddr),
    .stage_load(stage_load), .reg_save(reg_save), .stripe_valid(stripe_valid)
);

// File: tb/stripe_seq_test.sv
`timescale 1ns/1ps
module stripe_seq_test;

    localparam int P  = 4;
    localparam int MV = 16;
    localparam int CW = 16;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [4:0]    vcount = '0;
    logic          cfg_ren;
    logic [3:0]    cfg_raddr;
    logic [CW-1:0] cfg_rdata = '0;
    logic [CW-1:0] cfg_bus;
    logic [P-1:0]  stage_load;
    logic          st_ren;
    logic [3:0]    st_raddr;
    logic [SW-1:0] st_rdata = '0;
    logic          st_we;
    logic [3:0]    st_waddr;
    logic [SW-1:0] st_wdata;
    logic [P-1:0]  reg_save;
    logic [P-1:0]  stripe_valid;
    logic          dp_we = 1'b0;
    logic [1:0]    dp_slot = '0;
    logic [SW-1:0] dp_wdata = '0;
    logic [1:0]    obs_slot = '0;
    logic [SW-1:0] obs_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [SW-1:0] smem [MV];

    always #4 clk = ~clk;

    stripe_seq #(.NUM_SLOTS(P), .MAX_VSTAGES(MV), .CFG_W(CW),
                 .PE_COUNT(2), .PE_W(4)) uut (.*);

    function automatic logic [CW-1:0] cfgval(int v);
        return 16'hC000 + 16'(v * 257);
    endfunction

    // memory models, one-cycle read latency, image rebuilt in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MV; i++) smem[i] <= 8'hA0 + 8'(i);
        end else begin
            if (cfg_ren) cfg_rdata <= cfgval(int'(cfg_raddr));
            if (st_ren)  st_rdata  <= smem[st_raddr];
            if (st_we)   smem[st_waddr] <= st_wdata;
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        dp_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic go(int n);
        start  = 1'b1;
        vcount = 5'(n);
        @(negedge clk);
        start  = 1'b0;
    endtask

    localparam int SCEN [4] = '{3, 4, 6, 9};

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: quiet after reset
        do_reset();
        chk("R1 cfg_ren", cfg_ren, 0);
        chk("R1 st_we", st_we, 0);
        chk("R1 stage_load", stage_load, 0);
        chk("R1 stripe_valid", stripe_valid, 0);

        // table-driven scenarios
        foreach (SCEN[s]) begin
            int n;
            n = SCEN[s];
            do_reset();
            go(n);
            for (int k = 0; k < 14; k++) begin
                bit ren, ld, sv, ob;
                ren = (n > P) || (k < n);
                ld  = (k >= 1) && ((n > P) || (k - 1 < n));
                sv  = (n > P) && (k >= P);
                ob  = (k >= 2) && ((n > P) || (k - 2 < n));
                obs_slot = ob ? 2'((k - 2) % P) : 2'd0;
                #1;
                chk("R2 cfg_ren", cfg_ren, ren);
                if (ren) chk("R2 cfg_raddr", cfg_raddr, (k % n));
                chk("R3 stage_load", stage_load, ld ? (1 << ((k - 1) % P)) : 0);
                if (ld) begin
                    chk("R3 cfg_bus", cfg_bus, cfgval((k - 1) % n));
                    chk("R7 loading slot not valid",
                        stripe_valid & P'(1 << ((k - 1) % P)), 0);
                end
                chk("R5 reg_save", reg_save, sv ? (1 << (k % P)) : 0);
                if (sv) begin
                    chk("R5 st_waddr", st_waddr, ((k - P) % n));
                    chk("R5 st_wdata", st_wdata, 8'hA0 + ((k - P) % n));
                end
                if (ob) chk("R4 restored", obs_data, 8'hA0 + ((k - 2) % n));
                if (n <= P && k >= n + 1) begin
                    chk("R6 stripe_valid", stripe_valid, (1 << n) - 1);
                    chk("R6 no spill", st_we, 0);
                end
                @(negedge clk);
            end
        end

        // R4/R5/R8: spill and refill of a datapath-written value, N=5
        do_reset();
        go(5);                                  // now k=0
        @(negedge clk); @(negedge clk);         // k=2, slot0 valid
        dp_we = 1'b1; dp_slot = 2'd0; dp_wdata = 8'h55;
        @(negedge clk);                         // k=3
        obs_slot = 2'd0; #1;
        chk("R8 write to valid slot", obs_data, 8'h55);
        dp_slot = 2'd3; dp_wdata = 8'h77;       // slot3 not yet valid
        @(negedge clk);                         // k=4, slot0 being saved
        obs_slot = 2'd3; #1;
        chk("R8 write to unloaded slot dropped", obs_data, 8'h00);
        chk("R5 spill strobe", reg_save, 4'b0001);
        chk("R5 spill addr", st_waddr, 0);
        chk("R5 spill data", st_wdata, 8'h55);
        dp_slot = 2'd0; dp_wdata = 8'h66;
        @(negedge clk);                         // k=5
        dp_we = 1'b0;
        obs_slot = 2'd0; #1;
        chk("R8 write during save dropped", obs_data, 8'h55);
        obs_slot = 2'd3; #1;
        chk("R4 slot3 restored", obs_data, 8'hA3);
        @(negedge clk); @(negedge clk);         // k=7, stage0 in slot1
        obs_slot = 2'd1; #1;
        chk("R4 R5 refill after spill", obs_data, 8'h55);

        // R9: restart while running
        do_reset();
        go(9);
        repeat (6) @(negedge clk);
        go(2);                                  // new k=0
        chk("R9 raddr restarts", cfg_raddr, 0);
        chk("R9 load cancelled", stage_load, 0);
        chk("R9 valid cleared", stripe_valid, 0);
        chk("R9 no spill", st_we, 0);
        @(negedge clk);
        chk("R9 first load slot0", stage_load, 4'b0001);
        repeat (2) @(negedge clk);
        chk("R9 R6 two stages", stripe_valid, 4'b0011);
        chk("R9 R6 idle", cfg_ren, 0);

        // R10: illegal counts ignored
        do_reset();
        go(0);
        chk("R10 zero count", cfg_ren, 0);
        go(20);
        chk("R10 oversize count", cfg_ren, 0);
        chk("R10 nothing valid", stripe_valid, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule